// File: doc/BRIEF.md
# Register Scoreboard Hazard Interlock

This block controls hazards for a strictly in-order pipeline with four stages: fetch, decode, execute and writeback. It keeps a ready bit for every architectural register. When an instruction leaves decode with a destination register, that bit is cleared. The bit is set again when the writeback strobe names the register. A decode-stage instruction that reads a register whose bit is still clear is held in decode. Fetch is held with it, and execute receives a no-op. Write-after-write and write-after-read orderings never hold anything back, so with no true dependence the pipeline issues one instruction per cycle.

Branches are not predicted. While a conditional branch sits in decode, and from then until the branch-resolved strobe, fetch keeps repeating its current slot and decode loads no-ops. In the cycle the strobe arrives, fetch is released so it can redirect to the correct path.

The decode-to-execute hand-off is a valid/ready pair. An instruction leaves decode in a cycle where `dec_valid` and `dec_ready` are both high. While `dec_valid` is high and `dec_ready` is low, the decode stage must keep presenting the same instruction. `dec_ready` depends combinationally on the decode fields and the writeback inputs, and never on `dec_valid` being low. The writeback and branch-resolve inputs cannot be back-pressured.

Top module: `sb_interlock`

## Requirements
- R1: After reset every register reads as ready, no branch is pending, and with `dec_valid` low all of `fetch_hold`, `dec_hold`, `dec_bubble`, `ex_bubble` are 0 and `dec_ready` is 1.
- R2: If a valid decode instruction names a nonzero source whose ready bit is clear, and writeback is not writing that register in the same cycle, then `dec_ready`=0 and `dec_hold`=`fetch_hold`=`ex_bubble`=1. Otherwise `dec_hold` and `ex_bubble` are 0.
- R3: An instruction that leaves decode with a nonzero destination clears that register's ready bit from the next cycle on.
- R4: `wb_en` with index `wb_dst` sets that register's ready bit. A decode read of the same register in that same cycle counts as ready.
- R5: Register 0 is always ready. Naming it as a source never stalls, and naming it as a destination clears nothing.
- R6: A pending write to the decode instruction's destination register (write after write), or a later write to a register it reads (write after read), never deasserts `dec_ready`.
- R7: While a valid branch (`dec_branch`=1) is in decode, and after it leaves decode until the cycle `br_resolved` is high, `fetch_hold`=1. In that window `dec_bubble`=1 unless R2 holds decode. In the cycle `br_resolved` arrives, `fetch_hold` returns to 0 (absent other causes), and no hold remains afterwards.
- R8: If an instruction leaves decode with destination X in the same cycle that writeback sets X, then X ends up not ready.
- R9: A stream of valid instructions with no read-after-write dependence on pending registers is accepted with `dec_ready`=1 every cycle.
- R10: With `dec_valid`=0, `dec_ready`=1 and the scoreboard is not changed by the decode fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_ready | output | 1 | Instruction may leave decode this cycle |
| dec_src_a | input | IDXW | First source register index (0 when unused) |
| dec_src_b | input | IDXW | Second source register index (0 when unused) |
| dec_dst | input | IDXW | Destination register index (0 when none) |
| dec_branch | input | 1 | Decode instruction is a conditional branch |
| wb_en | input | 1 | Writeback strobe |
| wb_dst | input | IDXW | Register written back |
| br_resolved | input | 1 | Outcome of the pending branch is known |
| fetch_hold | output | 1 | Fetch repeats its current slot |
| dec_hold | output | 1 | Decode keeps its current instruction |
| dec_bubble | output | 1 | Decode loads a no-op instead of the fetch output |
| ex_bubble | output | 1 | Execute receives a no-op |

## Verification
The bench goes after the back-to-back dependence, where the consumer must wait exactly one cycle. A design without the writeback bypass would wait two cycles, and one that skips the clear would not wait at all. It drives the clear and the set of the same register in one cycle, where a wrong priority lets a later reader run early. It also drives register 0 as source and destination, where a design that tracks it would stall forever. Branch cases check that fetch is frozen while the branch is in decode and until the resolve cycle, not one cycle longer. Random traffic with held instructions under stall is compared against a bench model of the ready bits.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic {
    BR_IDLE = 1'b0,
    BR_WAIT = 1'b1
  } br_state_e;

  typedef struct packed {
    logic fetch_hold;
    logic dec_hold;
    logic dec_bubble;
    logic ex_bubble;
  } sb_ctl_t;

endpackage

// File: rtl/sb_valid_bits.sv
module sb_valid_bits #(
  parameter int NREGS = 32,
  parameter int IDXW  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDXW-1:0]  set_idx,
  input  logic             clr_en,
  input  logic [IDXW-1:0]  clr_idx,
  output logic [NREGS-1:0] avail
);

  logic [NREGS-1:0] rdy_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      // register 0 is hard-wired ready
      assign rdy_q[g] = 1'b1;
      assign avail[g] = 1'b1;
    end else begin : g_track
      logic hit_set;
      logic hit_clr;
      assign hit_set = set_en && (set_idx == IDXW'(g));
      assign hit_clr = clr_en && (clr_idx == IDXW'(g));

      always_ff @(posedge clk) begin
        if (!rst_n)       rdy_q[g] <= 1'b1;
        else if (hit_clr) rdy_q[g] <= 1'b0;  // new pending write wins
        else if (hit_set) rdy_q[g] <= 1'b1;
      end

      // writeback in the same cycle counts as available
      assign avail[g] = rdy_q[g] | hit_set;
    end
  end

endmodule

// File: rtl/sb_raw_check.sv
module sb_raw_check #(
  parameter int NREGS = 32,
  parameter int IDXW  = $clog2(NREGS),
  parameter int NSRC  = 2
) (
  input  logic                      req,
  input  logic [NSRC-1:0][IDXW-1:0] src,
  input  logic [NREGS-1:0]          avail,
  output logic                      raw
);

  logic [NSRC-1:0] hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = (src[s] != '0) && !avail[src[s]];
  end

  assign raw = req && (|hit);

endmodule

// File: rtl/sb_branch_ctl.sv
module sb_branch_ctl
  import sb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic br_in_dec,
  input  logic br_issue,
  input  logic resolved,
  output logic br_wait
);

  br_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (br_issue)                          st_d = BR_WAIT;
    else if (st_q == BR_WAIT && resolved)  st_d = BR_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= BR_IDLE;
    else        st_q <= st_d;
  end

  assign br_wait = ((st_q == BR_WAIT) && !resolved) || br_in_dec;

endmodule

// File: rtl/sb_interlock.sv
module sb_interlock
  import sb_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int IDXW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  output logic            dec_ready,
  input  logic [IDXW-1:0] dec_src_a,
  input  logic [IDXW-1:0] dec_src_b,
  input  logic [IDXW-1:0] dec_dst,
  input  logic            dec_branch,
  input  logic            wb_en,
  input  logic [IDXW-1:0] wb_dst,
  input  logic            br_resolved,
  output logic            fetch_hold,
  output logic            dec_hold,
  output logic            dec_bubble,
  output logic            ex_bubble
);

  localparam int NSRC = 2;

  logic [NREGS-1:0]          avail;
  logic [NSRC-1:0][IDXW-1:0] srcs;
  logic                      raw;
  logic                      issue;
  logic                      br_wait;
  sb_ctl_t                   ctl;

  assign srcs  = {dec_src_b, dec_src_a};
  assign issue = dec_valid && !raw;

  sb_valid_bits #(.NREGS(NREGS), .IDXW(IDXW)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (wb_en),
    .set_idx (wb_dst),
    .clr_en  (issue && (dec_dst != '0)),
    .clr_idx (dec_dst),
    .avail   (avail)
  );

  sb_raw_check #(.NREGS(NREGS), .IDXW(IDXW), .NSRC(NSRC)) u_raw (
    .req   (dec_valid),
    .src   (srcs),
    .avail (avail),
    .raw   (raw)
  );

  sb_branch_ctl u_br (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_in_dec (dec_valid && dec_branch),
    .br_issue  (issue && dec_branch),
    .resolved  (br_resolved),
    .br_wait   (br_wait)
  );

  always_comb begin
    ctl.fetch_hold = raw || br_wait;
    ctl.dec_hold   = raw;
    ctl.dec_bubble = br_wait && !raw;
    ctl.ex_bubble  = raw;
  end

  assign dec_ready  = !raw;
  assign fetch_hold = ctl.fetch_hold;
  assign dec_hold   = ctl.dec_hold;
  assign dec_bubble = ctl.dec_bubble;
  assign ex_bubble  = ctl.ex_bubble;

endmodule

// File: rtl/sb_interlock_chk.sv
module sb_interlock_chk #(
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic            dec_ready,
  input logic [IDXW-1:0] dec_src_a,
  input logic [IDXW-1:0] dec_src_b,
  input logic [IDXW-1:0] dec_dst,
  input logic            dec_branch,
  input logic            wb_en,
  input logic [IDXW-1:0] wb_dst,
  input logic            br_resolved,
  input logic            fetch_hold,
  input logic            dec_hold,
  input logic            dec_bubble,
  input logic            ex_bubble
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  stall_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |-> (fetch_hold && dec_hold && ex_bubble && !dec_bubble));

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (dec_ready && !dec_hold && !ex_bubble));

  // R5
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_src_a == '0 && dec_src_b == '0) |-> dec_ready);

  // R4
  wb_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && wb_en && wb_dst == dec_src_a && dec_src_b == '0) |-> dec_ready);

  // R3
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(dec_valid && dec_ready && dec_dst != '0) &&
     dec_valid && dec_src_a == $past(dec_dst) &&
     !(wb_en && wb_dst == dec_src_a)) |-> !dec_ready);

  // R7
  branch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(dec_valid && dec_ready && dec_branch) && !br_resolved)
      |-> fetch_hold);

  // R7
  branch_in_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_branch) |-> fetch_hold);

endmodule

bind sb_interlock sb_interlock_chk #(.IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dec_valid   (dec_valid),
  .dec_ready   (dec_ready),
  .dec_src_a   (dec_src_a),
  .dec_src_b   (dec_src_b),
  .dec_dst     (dec_dst),
  .dec_branch  (dec_branch),
  .wb_en       (wb_en),
  .wb_dst      (wb_dst),
  .br_resolved (br_resolved),
  .fetch_hold  (fetch_hold),
  .dec_hold    (dec_hold),
  .dec_bubble  (dec_bubble),
  .ex_bubble   (ex_bubble)
);

// File: tb/sb_interlock_tb.sv
module sb_interlock_tb;

  localparam int NREGS = 32;
  localparam int IDXW  = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dec_valid = 1'b0;
  logic [IDXW-1:0] dec_src_a = '0;
  logic [IDXW-1:0] dec_src_b = '0;
  logic [IDXW-1:0] dec_dst = '0;
  logic            dec_branch = 1'b0;
  logic            wb_en = 1'b0;
  logic [IDXW-1:0] wb_dst = '0;
  logic            br_resolved = 1'b0;
  logic            dec_ready, fetch_hold, dec_hold, dec_bubble, ex_bubble;

  int total = 0;
  int bad = 0;

  // bench model state
  logic [NREGS-1:0] m_rdy;
  logic             m_pend;

  always #5 clk = ~clk;

  sb_interlock #(.NREGS(NREGS), .IDXW(IDXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
    .dec_branch(dec_branch), .wb_en(wb_en), .wb_dst(wb_dst),
    .br_resolved(br_resolved), .fetch_hold(fetch_hold), .dec_hold(dec_hold),
    .dec_bubble(dec_bubble), .ex_bubble(ex_bubble)
  );

  function automatic logic avail_f(input logic [IDXW-1:0] r);
    return (r == '0) || m_rdy[r] || (wb_en && wb_dst == r);
  endfunction

  function automatic logic raw_f();
    return dec_valid && (!avail_f(dec_src_a) || !avail_f(dec_src_b));
  endfunction

  function automatic logic bwait_f();
    return (m_pend && !br_resolved) || (dec_valid && dec_branch);
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // drive at negedge, check after settling, then advance the model past the posedge
  task automatic step(input string tag, input logic v, input logic [IDXW-1:0] a,
                      input logic [IDXW-1:0] b, input logic [IDXW-1:0] d, input logic br,
                      input logic we, input logic [IDXW-1:0] wd, input logic res);
    logic raw, bw;
    @(negedge clk);
    dec_valid = v; dec_src_a = a; dec_src_b = b; dec_dst = d; dec_branch = br;
    wb_en = we; wb_dst = wd; br_resolved = res;
    #1;
    raw = raw_f();
    bw  = bwait_f();
    chk(tag, "dec_ready",  dec_ready,  !raw);
    chk(tag, "fetch_hold", fetch_hold, raw || bw);
    chk(tag, "dec_hold",   dec_hold,   raw);
    chk(tag, "ex_bubble",  ex_bubble,  raw);
    chk(tag, "dec_bubble", dec_bubble, bw && !raw);
    if (we && wd != '0) m_rdy[wd] = 1'b1;
    if (v && !raw && d != '0) m_rdy[d] = 1'b0;
    if (v && !raw && br) m_pend = 1'b1;
    else if (m_pend && res) m_pend = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  initial begin : watchdog
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [IDXW-1:0] ra, rb, rd;
    logic rbr, stalled;
    m_rdy = '1;
    m_pend = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, every register ready
    idle("R1");
    step("R1", 1'b1, 5'd31, 5'd17, 5'd0, 1'b0, 1'b0, '0, 1'b0);

    // R3, R2: producer then dependent consumer; R4: writeback releases with bypass
    step("R3", 1'b1, 5'd1, 5'd2, 5'd5, 1'b0, 1'b0, '0, 1'b0);
    step("R2", 1'b1, 5'd5, 5'd0, 5'd6, 1'b0, 1'b0, '0, 1'b0);
    step("R4", 1'b1, 5'd5, 5'd0, 5'd6, 1'b0, 1'b1, 5'd5, 1'b0);
    step("R4", 1'b0, '0, '0, '0, 1'b0, 1'b1, 5'd6, 1'b0);

    // R5: register 0 as destination and source
    step("R5", 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, '0, 1'b0);
    step("R5", 1'b1, 5'd0, 5'd0, 5'd3, 1'b0, 1'b0, '0, 1'b0);
    // R2: src_b pending (r3), src_a is r0
    step("R2", 1'b1, 5'd0, 5'd3, 5'd0, 1'b0, 1'b0, '0, 1'b0);
    step("R4", 1'b1, 5'd0, 5'd3, 5'd0, 1'b0, 1'b1, 5'd3, 1'b0);

    // R6: write after write and write after read do not stall
    step("R6", 1'b1, 5'd1, 5'd2, 5'd7, 1'b0, 1'b0, '0, 1'b0);
    step("R6", 1'b1, 5'd1, 5'd2, 5'd7, 1'b0, 1'b0, '0, 1'b0);
    step("R6", 1'b1, 5'd8, 5'd0, 5'd8, 1'b0, 1'b0, '0, 1'b0);
    step("R6", 1'b1, 5'd9, 5'd0, 5'd9, 1'b0, 1'b1, 5'd7, 1'b0);
    step("R6", 1'b0, '0, '0, '0, 1'b0, 1'b1, 5'd8, 1'b0);
    step("R6", 1'b0, '0, '0, '0, 1'b0, 1'b1, 5'd9, 1'b0);

    // R8: clear and set of r10 in one cycle; clear wins
    step("R8", 1'b1, 5'd1, 5'd0, 5'd10, 1'b0, 1'b0, '0, 1'b0);
    step("R8", 1'b1, 5'd1, 5'd0, 5'd10, 1'b0, 1'b1, 5'd10, 1'b0);
    step("R8", 1'b1, 5'd10, 5'd0, 5'd0, 1'b0, 1'b0, '0, 1'b0);
    step("R8", 1'b1, 5'd10, 5'd0, 5'd0, 1'b0, 1'b1, 5'd10, 1'b0);

    // R10: invalid decode ignores pending source and does not clear its destination
    step("R3", 1'b1, 5'd0, 5'd0, 5'd11, 1'b0, 1'b0, '0, 1'b0);
    step("R10", 1'b0, 5'd11, 5'd11, 5'd12, 1'b0, 1'b0, '0, 1'b0);
    step("R10", 1'b1, 5'd12, 5'd0, 5'd0, 1'b0, 1'b1, 5'd11, 1'b0);

    // R7: branch in decode, frozen fetch until resolve, release in resolve cycle
    step("R7", 1'b1, 5'd1, 5'd2, 5'd0, 1'b1, 1'b0, '0, 1'b0);
    idle("R7");
    idle("R7");
    step("R7", 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 1'b1);
    idle("R7");
    // R7: branch stalled by a dependence keeps decode held, not bubbled
    step("R7", 1'b1, 5'd0, 5'd0, 5'd13, 1'b0, 1'b0, '0, 1'b0);
    step("R7", 1'b1, 5'd13, 5'd0, 5'd0, 1'b1, 1'b0, '0, 1'b0);
    step("R7", 1'b1, 5'd13, 5'd0, 5'd0, 1'b1, 1'b1, 5'd13, 1'b0);
    step("R7", 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 1'b1);

    // R9: independent stream, one issue per cycle
    for (int i = 0; i < 8; i++)
      step("R9", 1'b1, IDXW'(16 + i), IDXW'(24 + i), IDXW'(16 + i), 1'b0, 1'b0, '0, 1'b0);
    for (int i = 0; i < 8; i++)
      step("R9", 1'b0, '0, '0, '0, 1'b0, 1'b1, IDXW'(16 + i), 1'b0);

    // random traffic on a small register set, instruction held while stalled
    stalled = 1'b0;
    ra = '0; rb = '0; rd = '0; rbr = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      logic v, we, res;
      logic [IDXW-1:0] wd;
      if (!stalled) begin
        ra  = IDXW'($urandom_range(0, 7));
        rb  = IDXW'($urandom_range(0, 7));
        rd  = IDXW'($urandom_range(0, 7));
        rbr = ($urandom_range(0, 9) == 0);
      end
      v   = m_pend ? 1'b0 : ($urandom_range(0, 3) != 0) || stalled;
      res = m_pend && ($urandom_range(0, 2) == 0);
      we  = ($urandom_range(0, 9) < 4);
      wd  = (stalled && $urandom_range(0, 1) == 1) ? ra : IDXW'($urandom_range(0, 7));
      step("RAND R2", v, ra, rb, rd, rbr, we, wd, res);
      stalled = v && !dec_ready;
    end

    idle("R10");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule